// File: doc/BRIEF.md
# Selectable-Polynomial PRBS Error Checker

This block measures the bit error rate of a link that carries a pseudo-random binary sequence. Data arrives as 16-bit words with a valid flag, already deserialised, with the earliest serial bit in the most significant position. A two-bit select chooses one of four standard polynomials. The checker first fills its shift register from received bits, which synchronises it to the stream. It then predicts every following word from its own register and counts both the bits it has compared and the bits that differ.

A matching word generator, `prbs_word_gen`, produces the same sequence under the same select. It has an error mask that flips chosen bits, so a stimulus source or a loopback test can inject known errors. If a word has more errors than a set limit, the checker treats lock as lost and synchronises again. A clear input starts a new measurement.

Top module: `prbs_err_checker`

## Requirements
- R1: The select picks the polynomial: 0 is x^7+x^6+1, 1 is x^15+x^14+1, 2 is x^23+x^18+1, 3 is x^31+x^28+1. Each new serial bit is the XOR of the bits received N and M positions earlier, where x^N+x^M+1 is the polynomial.
- R2: Within a 16-bit word, bit 15 carries the earliest serial bit and bit 0 the latest.
- R3: After reset, `locked` is 0 and both counters read 0.
- R4: After a reset, a clear or a change of select, the checker stays unlocked and counts nothing while it seeds. It shifts in one valid word for selects 0 and 1, and two valid words for selects 2 and 3. `locked` rises on the clock edge that takes the last of these words.
- R5: If the low N bits of the seeded register are all zero when seeding completes, the checker does not lock. It shifts in each further valid word until those bits are non-zero.
- R6: While locked, each valid word adds 16 to `bit_count`. It also adds to `err_count` the number of bits in which the word differs from the prediction. The prediction comes from the checker's own register, so one flipped bit counts once.
- R7: A word with more than LOSS_LIMIT differing bits (8 by default) is still counted, and it drops lock. Seeding then restarts with the next valid word. A word with exactly LOSS_LIMIT errors keeps lock.
- R8: `err_count` saturates at its all-ones value and does not wrap.
- R9: `clear` zeroes both counters and drops lock, and the word in that cycle is ignored. A change of select drops lock and ignores that cycle's word, but keeps the counters.
- R10: A cycle with `rx_valid` low changes neither counter nor the lock state.
- R11: The generator starts from an all-ones register after reset, after a clear and after a change of select. The reload happens whether or not `en` is high. The generator outputs words following R1 and R2, XORed with `err_mask`, and steps only when `en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear | input | 1 | Zero counters and restart seeding |
| poly_sel | input | 2 | Polynomial select (R1 encoding) |
| rx_valid | input | 1 | Received word is valid this cycle |
| rx_data | input | 16 | Received word, earliest bit in bit 15 |
| locked | output | 1 | Checker is synchronised and counting |
| bit_count | output | BIT_W | Bits compared while locked (default 40 bits, holds over 1.6e9) |
| err_count | output | ERR_W | Bits in error, saturating |

## Verification
The bench builds the checker with ERR_W set to 6 and keeps LOSS_LIMIT at 8 and BIT_W at 40. The narrow error counter reaches saturation after eight words that each carry the maximum tolerated eight errors, and those words also leave lock in place. The limit of 8 places the exact-threshold word and the loss-of-lock word one bit apart. All four polynomials are seeded from random non-zero states, so both the one-word and the two-word seeding paths are used. The generator is compared against an independent serial model for every select.

// File: rtl/prbs_pkg.sv
package prbs_pkg;

  localparam int WORD_W = 16;
  localparam int REG_W  = 32;
  localparam int ERRS_W = $clog2(WORD_W + 1);
  localparam int SCNT_W = 3;

  typedef enum logic [1:0] {
    POLY_7  = 2'd0,
    POLY_15 = 2'd1,
    POLY_23 = 2'd2,
    POLY_31 = 2'd3
  } poly_sel_e;

  typedef enum logic {
    ST_SEED = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;

  typedef struct packed {
    logic [REG_W-1:0]  state;
    logic [WORD_W-1:0] word;
  } adv_t;

  function automatic int poly_len(input logic [1:0] sel);
    case (poly_sel_e'(sel))
      POLY_7:  return 7;
      POLY_15: return 15;
      POLY_23: return 23;
      default: return 31;
    endcase
  endfunction

  function automatic int poly_tap(input logic [1:0] sel);
    case (poly_sel_e'(sel))
      POLY_7:  return 6;
      POLY_15: return 14;
      POLY_23: return 18;
      default: return 28;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] poly_mask(input logic [1:0] sel);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < poly_len(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [SCNT_W-1:0] seed_words(input logic [1:0] sel);
    return SCNT_W'((poly_len(sel) + WORD_W - 1) / WORD_W);
  endfunction

  // Sixteen serial steps of a Fibonacci register; first bit lands in the MSB.
  function automatic adv_t prbs_advance(input logic [REG_W-1:0] s_in,
                                        input logic [1:0] sel);
    adv_t r;
    logic [REG_W-1:0] s;
    logic nb;
    int hi;
    int lo;
    hi = poly_len(sel) - 1;
    lo = poly_tap(sel) - 1;
    s = s_in;
    r.word = '0;
    for (int k = 0; k < WORD_W; k++) begin
      nb = s[hi] ^ s[lo];
      r.word[WORD_W-1-k] = nb;
      s = {s[REG_W-2:0], nb};
    end
    r.state = s;
    return r;
  endfunction

endpackage

// File: rtl/prbs_rst_sync.sv
module prbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/prbs_predict.sv
module prbs_predict
  import prbs_pkg::*;
(
  input  logic [REG_W-1:0]  cur_state,
  input  logic [1:0]        sel,
  output logic [WORD_W-1:0] pred_word,
  output logic [REG_W-1:0]  pred_state
);
  adv_t adv;

  always_comb begin
    adv        = prbs_advance(cur_state, sel);
    pred_word  = adv.word;
    pred_state = adv.state;
  end
endmodule

// File: rtl/prbs_lock_ctl.sv
module prbs_lock_ctl
  import prbs_pkg::*;
#(
  parameter int LOSS_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [1:0]        sel,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_data,
  input  logic [REG_W-1:0]  pred_state,
  input  logic [ERRS_W-1:0] word_errs,
  output logic [REG_W-1:0]  cur_state,
  output logic [1:0]        sel_used,
  output logic              locked,
  output logic              count_en
);
  lock_st_e          st_q,   st_d;
  logic [REG_W-1:0]  sreg_q, sreg_d;
  logic [SCNT_W-1:0] cnt_q,  cnt_d;
  logic [1:0]        sel_q,  sel_d;
  logic              restart;
  logic [REG_W-1:0]  shifted;
  logic [SCNT_W-1:0] need;
  logic [SCNT_W-1:0] cnt_inc;

  always_comb begin
    restart  = clear || (sel != sel_q);
    shifted  = {sreg_q[REG_W-WORD_W-1:0], rx_data};
    need     = seed_words(sel_q);
    cnt_inc  = cnt_q + SCNT_W'(1);
    st_d     = st_q;
    sreg_d   = sreg_q;
    cnt_d    = cnt_q;
    sel_d    = sel_q;
    if (restart) begin
      st_d  = ST_SEED;
      cnt_d = '0;
      sel_d = sel;
    end else if (rx_valid) begin
      case (st_q)
        ST_SEED: begin
          sreg_d = shifted;
          if (cnt_inc >= need) begin
            cnt_d = need;
            if ((shifted & poly_mask(sel_q)) != '0) begin
              st_d  = ST_LOCK;
              cnt_d = '0;
            end
          end else begin
            cnt_d = cnt_inc;
          end
        end
        default: begin
          if (word_errs > ERRS_W'(LOSS_LIMIT)) begin
            st_d  = ST_SEED;
            cnt_d = '0;
          end else begin
            sreg_d = pred_state;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SEED;
      sreg_q <= '0;
      cnt_q  <= '0;
      sel_q  <= '0;
    end else begin
      st_q   <= st_d;
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
    end
  end

  assign cur_state = sreg_q;
  assign sel_used  = sel_q;
  assign locked    = (st_q == ST_LOCK);
  assign count_en  = (st_q == ST_LOCK) && rx_valid && !restart;
endmodule

// File: rtl/prbs_err_accum.sv
module prbs_err_accum
  import prbs_pkg::*;
#(
  parameter int BIT_W = 40,
  parameter int ERR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              count_en,
  input  logic [WORD_W-1:0] rx_data,
  input  logic [WORD_W-1:0] pred_word,
  output logic [ERRS_W-1:0] word_errs,
  output logic [BIT_W-1:0]  bit_count,
  output logic [ERR_W-1:0]  err_count
);
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic [ERR_W:0]   err_sum;
  logic [WORD_W-1:0] diff;

  always_comb begin
    diff      = rx_data ^ pred_word;
    word_errs = '0;
    for (int i = 0; i < WORD_W; i++) begin
      word_errs = word_errs + ERRS_W'(diff[i]);
    end
  end

  always_comb begin
    bit_d   = bit_q;
    err_d   = err_q;
    err_sum = {1'b0, err_q} + (ERR_W+1)'(word_errs);
    if (clear) begin
      bit_d = '0;
      err_d = '0;
    end else if (count_en) begin
      bit_d = bit_q + BIT_W'(WORD_W);
      err_d = err_sum[ERR_W] ? '1 : err_sum[ERR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      err_q <= '0;
    end else begin
      bit_q <= bit_d;
      err_q <= err_d;
    end
  end

  assign bit_count = bit_q;
  assign err_count = err_q;
endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
  import prbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [1:0]        poly_sel,
  input  logic              en,
  input  logic [WORD_W-1:0] err_mask,
  output logic [WORD_W-1:0] data_out
);
  logic             rst_n_i;
  logic [REG_W-1:0] st_q, st_d;
  logic [1:0]       sel_q;
  adv_t             adv;

  prbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  always_comb begin
    adv  = prbs_advance(st_q, sel_q);
    st_d = st_q;
    if (clear || (poly_sel != sel_q)) st_d = '1;
    else if (en)                      st_d = adv.state;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q  <= '1;
      sel_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= poly_sel;
    end
  end

  assign data_out = adv.word ^ err_mask;
endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
  import prbs_pkg::*;
#(
  parameter int BIT_W      = 40,
  parameter int ERR_W      = 32,
  parameter int LOSS_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [1:0]       poly_sel,
  input  logic             rx_valid,
  input  logic [15:0]      rx_data,
  output logic             locked,
  output logic [BIT_W-1:0] bit_count,
  output logic [ERR_W-1:0] err_count
);
  logic              rst_n_i;
  logic [REG_W-1:0]  cur_state;
  logic [REG_W-1:0]  pred_state;
  logic [WORD_W-1:0] pred_word;
  logic [ERRS_W-1:0] word_errs;
  logic [1:0]        sel_used;
  logic              count_en;

  prbs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  prbs_predict u_pred (
    .cur_state(cur_state), .sel(sel_used),
    .pred_word(pred_word), .pred_state(pred_state)
  );

  prbs_lock_ctl #(.LOSS_LIMIT(LOSS_LIMIT)) u_lock (
    .clk(clk), .rst_n(rst_n_i), .clear(clear), .sel(poly_sel),
    .rx_valid(rx_valid), .rx_data(rx_data), .pred_state(pred_state),
    .word_errs(word_errs), .cur_state(cur_state), .sel_used(sel_used),
    .locked(locked), .count_en(count_en)
  );

  prbs_err_accum #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_acc (
    .clk(clk), .rst_n(rst_n_i), .clear(clear), .count_en(count_en),
    .rx_data(rx_data), .pred_word(pred_word), .word_errs(word_errs),
    .bit_count(bit_count), .err_count(err_count)
  );
endmodule

// File: rtl/prbs_err_checker_chk.sv
module prbs_err_checker_chk #(
  parameter int BIT_W = 40,
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic [1:0]       poly_sel,
  input logic             rx_valid,
  input logic             locked,
  input logic [BIT_W-1:0] bit_count,
  input logic [ERR_W-1:0] err_count
);
  // R9
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!locked && bit_count == '0 && err_count == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !clear) |=> ($stable(bit_count) && $stable(err_count)));

  // R4
  seed_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !clear) |=> ($stable(bit_count) && $stable(err_count)));

  // R4
  lock_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !rx_valid) |=> !locked);

  // R8
  err_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (err_count >= $past(err_count)));

  // R6
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rx_valid && !clear && poly_sel == $past(poly_sel))
      |=> (bit_count == $past(bit_count) + BIT_W'(16)));
endmodule

bind prbs_err_checker prbs_err_checker_chk #(.BIT_W(BIT_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .poly_sel(poly_sel),
  .rx_valid(rx_valid), .locked(locked), .bit_count(bit_count),
  .err_count(err_count)
);

// File: tb/prbs_err_checker_bench.sv
module prbs_err_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_W      = 40;
  localparam int ERR_W      = 6;
  localparam int LOSS_LIMIT = 8;
  localparam longint ERR_MAX = (64'd1 << ERR_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             clear;
  logic [1:0]       poly_sel;
  logic             rx_valid;
  logic [15:0]      rx_data;
  logic             locked;
  logic [BIT_W-1:0] bit_count;
  logic [ERR_W-1:0] err_count;

  logic        g_clear;
  logic [1:0]  g_sel;
  logic        g_en;
  logic [15:0] g_mask;
  logic [15:0] g_out;

  int checks;
  int errors;
  logic [31:0] ms;
  longint exp_bits;
  longint exp_err;

  prbs_err_checker #(.BIT_W(BIT_W), .ERR_W(ERR_W), .LOSS_LIMIT(LOSS_LIMIT))
    u_prbs_err_checker (
      .clk(clk), .rst_n(rst_n), .clear(clear), .poly_sel(poly_sel),
      .rx_valid(rx_valid), .rx_data(rx_data), .locked(locked),
      .bit_count(bit_count), .err_count(err_count)
    );

  prbs_word_gen u_gen (
    .clk(clk), .rst_n(rst_n), .clear(g_clear), .poly_sel(g_sel),
    .en(g_en), .err_mask(g_mask), .data_out(g_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int tap_n(input logic [1:0] s);
    case (s) 2'd0: return 7; 2'd1: return 15; 2'd2: return 23; default: return 31; endcase
  endfunction
  function automatic int tap_m(input logic [1:0] s);
    case (s) 2'd0: return 6; 2'd1: return 14; 2'd2: return 18; default: return 28; endcase
  endfunction

  // Serial model from R1/R2: returns {next state, word}.
  function automatic logic [47:0] model(input logic [31:0] s_in, input logic [1:0] s);
    logic [31:0] st;
    logic [15:0] w;
    logic b;
    st = s_in;
    w = '0;
    for (int k = 0; k < 16; k++) begin
      b = st[tap_n(s)-1] ^ st[tap_m(s)-1];
      w[15-k] = b;
      st = {st[30:0], b};
    end
    return {st, w};
  endfunction

  function automatic int pop16(input logic [15:0] v);
    int c;
    c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic longint sat(input longint v);
    return (v > ERR_MAX) ? ERR_MAX : v;
  endfunction

  // Drive one word at a negedge, return at the following negedge.
  task automatic drive(input logic [15:0] w, input logic v);
    rx_data  = w;
    rx_valid = v;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic model_word(input logic [15:0] mask);
    logic [47:0] r;
    r  = model(ms, poly_sel);
    ms = r[47:16];
    drive(r[15:0] ^ mask, 1'b1);
  endtask

  task automatic do_clear(input logic [1:0] sel);
    poly_sel = sel;
    clear    = 1'b1;
    rx_valid = 1'b1;
    rx_data  = 16'(($urandom));
    @(posedge clk);
    @(negedge clk);
    clear    = 1'b0;
    rx_valid = 1'b0;
    exp_bits = 0;
    exp_err  = 0;
  endtask

  task automatic check_counts(input string req);
    check(bit_count == BIT_W'(exp_bits), req, "bit_count", longint'(bit_count), exp_bits);
    check(err_count == ERR_W'(exp_err),  req, "err_count", longint'(err_count), exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] r;
    logic [31:0] gs;
    logic [15:0] mk;
    int need;
    checks = 0; errors = 0;
    void'($urandom(32'd12345));
    rst_n = 1'b0; clear = 1'b0; poly_sel = 2'd0; rx_valid = 1'b0; rx_data = '0;
    g_clear = 1'b0; g_sel = 2'd0; g_en = 1'b0; g_mask = '0;
    exp_bits = 0; exp_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: reset state
    check(locked == 1'b0, "R3", "locked after reset", longint'(locked), 0);
    check_counts("R3");

    // R11, R1, R2: generator against serial model for each select
    for (int p = 0; p < 4; p++) begin
      g_sel = 2'(p); g_clear = 1'b1; g_en = 1'b1;
      @(negedge clk);
      g_clear = 1'b0;
      gs = 32'hFFFF_FFFF;
      for (int k = 0; k < 6; k++) begin
        mk = (k % 2 == 1) ? 16'(($urandom)) : 16'h0000;
        g_en = (k != 3);
        g_mask = mk;
        #1;
        r = model(gs, 2'(p));
        check(g_out == (r[15:0] ^ mk), "R11/R1/R2", "generator word", longint'(g_out),
              longint'(r[15:0] ^ mk));
        @(negedge clk);
        if (k != 3) gs = r[47:16];
      end
      g_en = 1'b0; g_mask = '0;
    end

    // R4, R6, R1: seed and measure for each select with random error masks
    for (int p = 0; p < 4; p++) begin
      do_clear(2'(p));
      ms = $urandom | 32'h1;
      need = (tap_n(2'(p)) + 15) / 16;
      for (int k = 0; k < need; k++) begin
        model_word(16'h0000);
        check(locked == (k == need - 1), "R4", "lock during seeding", longint'(locked),
              longint'(k == need - 1));
        check_counts("R4");
      end
      for (int k = 0; k < 12; k++) begin
        mk = 16'(($urandom)) & 16'(($urandom)) & 16'(($urandom));
        if (pop16(mk) > LOSS_LIMIT) mk = 16'h0000;
        model_word(mk);
        exp_bits += 16;
        exp_err = sat(exp_err + pop16(mk));
      end
      check(locked == 1'b1, "R6", "locked after clean run", longint'(locked), 1);
      check_counts("R6");
    end

    // R7: threshold and loss of lock on select 1
    do_clear(2'd1);
    ms = $urandom | 32'h1;
    model_word(16'h0000);
    model_word(16'h00FF);
    exp_bits += 16; exp_err = sat(exp_err + 8);
    check(locked == 1'b1, "R7", "locked at exactly limit", longint'(locked), 1);
    check_counts("R7");
    model_word(16'h01FF);
    exp_bits += 16; exp_err = sat(exp_err + 9);
    check(locked == 1'b0, "R7", "lock lost above limit", longint'(locked), 0);
    check_counts("R7");
    model_word(16'h0000);
    check(locked == 1'b1, "R7", "relock after one word", longint'(locked), 1);
    check_counts("R7");
    model_word(16'h0000);
    exp_bits += 16;
    check_counts("R7");

    // R10: invalid cycles with random data
    for (int k = 0; k < 3; k++) drive(16'(($urandom)), 1'b0);
    check(locked == 1'b1, "R10", "lock kept while idle", longint'(locked), 1);
    check_counts("R10");

    // R9: select change keeps counters and drops lock
    poly_sel = 2'd3;
    drive(16'(($urandom)), 1'b1);
    check(locked == 1'b0, "R9", "lock dropped on select change", longint'(locked), 0);
    check_counts("R9");
    ms = $urandom | 32'h1;
    model_word(16'h0000);
    check(locked == 1'b0, "R4", "two-word seed, first word", longint'(locked), 0);
    model_word(16'h0000);
    check(locked == 1'b1, "R4", "two-word seed, second word", longint'(locked), 1);
    model_word(16'h0010);
    exp_bits += 16; exp_err = sat(exp_err + 1);
    check_counts("R6");

    // R9: clear with a valid word present
    do_clear(2'd3);
    check(locked == 1'b0, "R9", "lock dropped on clear", longint'(locked), 0);
    check_counts("R9");

    // R8: saturation on select 0
    do_clear(2'd0);
    ms = $urandom | 32'h1;
    model_word(16'h0000);
    for (int k = 0; k < 9; k++) begin
      model_word(16'hAA55);
      exp_bits += 16; exp_err = sat(exp_err + 8);
    end
    check(locked == 1'b1, "R8", "lock kept at limit", longint'(locked), 1);
    check(err_count == ERR_W'(ERR_MAX), "R8", "err_count saturated", longint'(err_count), ERR_MAX);
    check_counts("R8");

    // R5: all-zero seed does not lock
    do_clear(2'd1);
    do_clear(2'd0);
    drive(16'h0000, 1'b1);
    check(locked == 1'b0, "R5", "zero seed, first word", longint'(locked), 0);
    drive(16'h0000, 1'b1);
    check(locked == 1'b0, "R5", "zero seed, second word", longint'(locked), 0);
    ms = $urandom | 32'h1;
    model_word(16'h0000);
    check(locked == 1'b1, "R5", "lock after non-zero word", longint'(locked), 1);
    model_word(16'h0000);
    exp_bits += 16;
    check_counts("R5");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule